// File: doc/BRIEF.md
# Dual-Bank Status Calendar Controller

This block controls the receive-side status channel of an SPI-4.2 style link. Software reaches it through a small word-addressed register bus. The block holds two banks of calendar settings. Each bank has a repetition count, a calendar length and an indirectly addressed calendar RAM. A built-in sequencer turns the active bank into a stream of 2-bit status words. Each frame of that stream starts with a framing word and ends with a parity word.

Software programs the bank that is not in use while the other bank runs, then requests a switch. The switch takes effect cleanly at the next frame boundary, and the frame announces it through a select word. From reset the block is held in a disabled state that sends framing words only, until software has loaded a calendar and clears the disable bit. An external input can force the same disabled behaviour at any time.

Top module: `sc_cal_ctrl`

## Requirements
- R1: A read of address 0 returns the identity word: bits 12:0 hold the TYPE_CODE parameter and bits 15:13 hold the BLK_ID parameter.
- R2: Address 1 is the control word. Bit 0 enables bank switching (called hbwr below). Bit 1 is the disable bit. Bit 2 is the requested bank. Bit 3 is the active bank and is read-only. Bit 4 reads 0. Bit 5 is a read-only copy of the disabled state that the sequencer has latched. After reset, address 1 reads 0x0022.
- R3: The sequencer samples the effective disable only at a frame boundary. While that sampled value is 1, stat_o carries 2'b11 and frame_start_o is 1 on every cycle. Once the disable is 0 at a boundary, normal frames resume.
- R4: The effective disable is the OR of the disable bit and force_frame_i.
- R5: The active bank changes only at a frame boundary. It then takes the requested bank when hbwr is 1, and bank 0 when hbwr is 0.
- R6: A frame sampled with hbwr = 1 carries a select word right after the framing word: 2'b01 for bank 0, 2'b10 for bank 1. A frame sampled with hbwr = 0 carries no select word.
- R7: A frame is sent in this order. First the framing word 2'b11. Then the select word, if there is one. Then bits 1:0 of the active bank's RAM entries 0 to length-1, with the whole run repeated count times. Last comes a parity word equal to the XOR of all the earlier words of the frame. The count registers sit at addresses 2 and 3 and the length registers at addresses 4 and 5, bank 0 first in each pair.
- R8: Address 6 holds the RAM address. Its low RAM_AW bits select the RAM entry. A write to address 7 (bank 0) or address 8 (bank 1) stores the written byte in that bank's RAM at that address. A read of address 7 or 8 returns that RAM entry and also keeps it in the data register.
- R9: Read data appears on reg_rdata_o one cycle after the read strobe, together with a one-cycle reg_rvalid_o pulse. reg_rvalid_o is low at all other times.
- R10: While hbwr is 0, the bank-1 registers (addresses 3, 5 and 8) read as zero. Writes to them are dropped and do not raise err_o.
- R11: A write to a bank's registers is accepted only while the latched disable is 1 or while the other bank is active. Any other write to them is dropped, and it sets err_o, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid while reg_rvalid_o is high |
| reg_rvalid_o | output | 1 | Read data valid pulse |
| force_frame_i | input | 1 | External request for continuous framing |
| stat_o | output | 2 | Status word stream |
| frame_start_o | output | 1 | High on each framing-word cycle |
| err_o | output | 1 | Sticky flag for a blocked write |

## Verification
The properties assume that the read and write strobes are never high in the same cycle. The bench keeps to this because each bus task drives exactly one strobe for one cycle and then lowers it. The properties also assume that calendar lengths and counts are not changed under a running frame. This holds because the protection rule is part of the design, and the bench makes its blocked writes on purpose and checks that they have no effect. Bank-switch requests are issued right after a framing-word cycle, so every read-back of the control word falls well clear of the next boundary.

// File: rtl/sc_cal_pkg.sv
package sc_cal_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {ST_SYNC, ST_SEL, ST_CAL, ST_PAR} seq_st_e;

  localparam logic [3:0] A_ID   = 4'd0;
  localparam logic [3:0] A_CTL  = 4'd1;
  localparam logic [3:0] A_REP0 = 4'd2;
  localparam logic [3:0] A_LEN0 = 4'd4;
  localparam logic [3:0] A_RADR = 4'd6;
  localparam logic [3:0] A_DAT0 = 4'd7;

  localparam logic [1:0] W_SYNC = 2'b11;
  localparam logic [1:0] W_SEL0 = 2'b01;
  localparam logic [1:0] W_SEL1 = 2'b10;
endpackage

// File: rtl/sc_cal_regs.sv
module sc_cal_regs
  import sc_cal_pkg::*;
#(
  parameter int          LEN_W     = 10,
  parameter int          REP_W     = 8,
  parameter int          ENT_W     = 8,
  parameter int          RADR_W    = 10,
  parameter int          RAM_AW    = 6,
  parameter logic [12:0] TYPE_CODE = 13'h0A5C,
  parameter logic [2:0]  BLK_ID    = 3'd2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [3:0]                  addr_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic [REG_W-1:0]            rdata_o,
  output logic                        rvalid_o,
  input  logic                        act_i,
  input  logic                        dis_act_i,
  input  logic [RAM_AW-1:0]           slot_i,
  output logic                        hbwr_o,
  output logic                        rsfrm_o,
  output logic                        req_o,
  output logic                        err_o,
  output logic [1:0][REP_W-1:0]       rep_o,
  output logic [1:0][LEN_W-1:0]       len_o,
  output logic [1:0][1:0]             ent_o
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic              hbwr_q, rsfrm_q, req_q, err_q, rvalid_q;
  logic [RADR_W-1:0] radr_q;
  logic [3:0]        raddr_q;
  logic [RAM_AW-1:0] ram_idx;
  logic [1:0]        blocked;
  logic [1:0][REP_W-1:0] rep_rd;
  logic [1:0][LEN_W-1:0] len_rd;
  logic [1:0][ENT_W-1:0] dat_rd;
  logic              unused_wdata;

  assign ram_idx      = radr_q[RAM_AW-1:0];
  assign unused_wdata = ^wdata_i;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [REP_W-1:0] rep_q;
    logic [LEN_W-1:0] len_q;
    logic [ENT_W-1:0] dat_q;
    logic [ENT_W-1:0] mem_q [RAM_DEPTH];
    logic live, open_wr, hit_rep, hit_len, hit_dat, wr_ok;

    // bank 1 exists only while switching is enabled
    assign live    = (b == 0) || hbwr_q;
    assign open_wr = dis_act_i || (act_i != 1'(b));
    assign hit_rep = (addr_i == A_REP0 + 4'(b));
    assign hit_len = (addr_i == A_LEN0 + 4'(b));
    assign hit_dat = (addr_i == A_DAT0 + 4'(b));
    assign wr_ok   = wr_i && live && open_wr;
    assign blocked[b] = wr_i && live && !open_wr && (hit_rep || hit_len || hit_dat);

    always_ff @(posedge clk_i) begin
      if (wr_ok && hit_dat) mem_q[ram_idx] <= wdata_i[ENT_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rep_q <= '0;
        len_q <= '0;
        dat_q <= '0;
      end else begin
        if (wr_ok && hit_rep) rep_q <= wdata_i[REP_W-1:0];
        if (wr_ok && hit_len) len_q <= wdata_i[LEN_W-1:0];
        if (wr_ok && hit_dat)              dat_q <= wdata_i[ENT_W-1:0];
        else if (rd_i && live && hit_dat)  dat_q <= mem_q[ram_idx];
      end
    end

    assign rep_o[b]  = rep_q;
    assign len_o[b]  = len_q;
    assign ent_o[b]  = mem_q[slot_i][1:0];
    assign rep_rd[b] = live ? rep_q : '0;
    assign len_rd[b] = live ? len_q : '0;
    assign dat_rd[b] = live ? dat_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hbwr_q   <= 1'b0;
      rsfrm_q  <= 1'b1;
      req_q    <= 1'b0;
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      raddr_q  <= '0;
      radr_q   <= '0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) raddr_q <= addr_i;
      if (wr_i && addr_i == A_CTL) begin
        hbwr_q  <= wdata_i[0];
        rsfrm_q <= wdata_i[1];
        req_q   <= wdata_i[2];
      end
      if (wr_i && addr_i == A_RADR) radr_q <= wdata_i[RADR_W-1:0];
      if (|blocked) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (raddr_q)
      A_ID:          rdata_o = {BLK_ID, TYPE_CODE};
      A_CTL:         rdata_o = REG_W'({dis_act_i, 1'b0, act_i, req_q, rsfrm_q, hbwr_q});
      A_REP0:        rdata_o = REG_W'(rep_rd[0]);
      A_REP0 + 4'd1: rdata_o = REG_W'(rep_rd[1]);
      A_LEN0:        rdata_o = REG_W'(len_rd[0]);
      A_LEN0 + 4'd1: rdata_o = REG_W'(len_rd[1]);
      A_RADR:        rdata_o = REG_W'(radr_q);
      A_DAT0:        rdata_o = REG_W'(dat_rd[0]);
      A_DAT0 + 4'd1: rdata_o = REG_W'(dat_rd[1]);
      default:       rdata_o = '0;
    endcase
  end

  assign rvalid_o = rvalid_q;
  assign hbwr_o   = hbwr_q;
  assign rsfrm_o  = rsfrm_q;
  assign req_o    = req_q;
  assign err_o    = err_q;
endmodule

// File: rtl/sc_cal_seq.sv
module sc_cal_seq
  import sc_cal_pkg::*;
#(
  parameter int LEN_W  = 10,
  parameter int REP_W  = 8,
  parameter int RAM_AW = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  disable_i,
  input  logic                  hbwr_i,
  input  logic                  req_i,
  input  logic [1:0][REP_W-1:0] rep_i,
  input  logic [1:0][LEN_W-1:0] len_i,
  input  logic [1:0][1:0]       ent_i,
  output logic [RAM_AW-1:0]     slot_o,
  output logic                  act_o,
  output logic                  dis_act_o,
  output logic [1:0]            stat_o,
  output logic                  frame_start_o
);
  seq_st_e          st_q;
  logic             act_q, dis_q;
  logic [LEN_W-1:0] slot_q;
  logic [REP_W-1:0] cnt_q;
  logic [1:0]       par_q;
  logic             act_nxt, empty_nxt, empty_cur, last_slot, last_rep;

  assign act_nxt   = hbwr_i & req_i;
  assign empty_nxt = (len_i[act_nxt] == '0) || (rep_i[act_nxt] == '0);
  assign empty_cur = (len_i[act_q] == '0) || (rep_i[act_q] == '0);
  assign last_slot = (slot_q == len_i[act_q] - LEN_W'(1));
  assign last_rep  = (cnt_q == rep_i[act_q] - REP_W'(1));

  always_comb begin
    case (st_q)
      ST_SYNC: stat_o = W_SYNC;
      ST_SEL:  stat_o = act_q ? W_SEL1 : W_SEL0;
      ST_CAL:  stat_o = ent_i[act_q];
      default: stat_o = par_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SYNC;
      act_q  <= 1'b0;
      dis_q  <= 1'b1;
      slot_q <= '0;
      cnt_q  <= '0;
      par_q  <= '0;
    end else begin
      case (st_q)
        ST_SYNC: begin
          // frame boundary: bank, disable and select-word use are latched here
          act_q  <= act_nxt;
          dis_q  <= disable_i;
          slot_q <= '0;
          cnt_q  <= '0;
          par_q  <= W_SYNC;
          if (!disable_i) st_q <= hbwr_i ? ST_SEL : (empty_nxt ? ST_PAR : ST_CAL);
        end
        ST_SEL: begin
          par_q <= par_q ^ stat_o;
          st_q  <= empty_cur ? ST_PAR : ST_CAL;
        end
        ST_CAL: begin
          par_q <= par_q ^ stat_o;
          if (last_slot) begin
            slot_q <= '0;
            if (last_rep) st_q  <= ST_PAR;
            else          cnt_q <= cnt_q + 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: st_q <= ST_SYNC;
      endcase
    end
  end

  assign slot_o        = slot_q[RAM_AW-1:0];
  assign act_o         = act_q;
  assign dis_act_o     = dis_q;
  assign frame_start_o = (st_q == ST_SYNC);
endmodule

// File: rtl/sc_cal_ctrl.sv
module sc_cal_ctrl
  import sc_cal_pkg::*;
#(
  parameter int          LEN_W     = 10,
  parameter int          REP_W     = 8,
  parameter int          ENT_W     = 8,
  parameter int          RADR_W    = 10,
  parameter int          RAM_AW    = 6,
  parameter logic [12:0] TYPE_CODE = 13'h0A5C,
  parameter logic [2:0]  BLK_ID    = 3'd2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        reg_rvalid_o,
  input  logic        force_frame_i,
  output logic [1:0]  stat_o,
  output logic        frame_start_o,
  output logic        err_o
);
  logic                  act_w, dis_act_w, hbwr_w, rsfrm_w, req_w;
  logic [RAM_AW-1:0]     slot_w;
  logic [1:0][REP_W-1:0] rep_w;
  logic [1:0][LEN_W-1:0] len_w;
  logic [1:0][1:0]       ent_w;

  sc_cal_regs #(
    .LEN_W(LEN_W), .REP_W(REP_W), .ENT_W(ENT_W), .RADR_W(RADR_W),
    .RAM_AW(RAM_AW), .TYPE_CODE(TYPE_CODE), .BLK_ID(BLK_ID)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .rvalid_o  (reg_rvalid_o),
    .act_i     (act_w),
    .dis_act_i (dis_act_w),
    .slot_i    (slot_w),
    .hbwr_o    (hbwr_w),
    .rsfrm_o   (rsfrm_w),
    .req_o     (req_w),
    .err_o     (err_o),
    .rep_o     (rep_w),
    .len_o     (len_w),
    .ent_o     (ent_w)
  );

  sc_cal_seq #(.LEN_W(LEN_W), .REP_W(REP_W), .RAM_AW(RAM_AW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .disable_i     (rsfrm_w | force_frame_i),
    .hbwr_i        (hbwr_w),
    .req_i         (req_w),
    .rep_i         (rep_w),
    .len_i         (len_w),
    .ent_i         (ent_w),
    .slot_o        (slot_w),
    .act_o         (act_w),
    .dis_act_o     (dis_act_w),
    .stat_o        (stat_o),
    .frame_start_o (frame_start_o)
  );
endmodule

// File: rtl/sc_cal_ctrl_chk.sv
module sc_cal_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_rd_i,
  input logic       reg_rvalid_o,
  input logic       force_frame_i,
  input logic [1:0] stat_o,
  input logic       frame_start_o,
  input logic       err_o,
  input logic       act_i,
  input logic       hbwr_i,
  input logic       rsfrm_i
);
  a_r3_hold_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o && (rsfrm_i || force_frame_i) |=> frame_start_o && stat_o == 2'b11);

  a_r5_switch_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |=> $stable(act_i));

  a_r5_bank0_without_hbwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o && !hbwr_i |=> !act_i);

  a_r6_sel_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o && hbwr_i && !(rsfrm_i || force_frame_i) |=>
      stat_o == (act_i ? 2'b10 : 2'b01));

  a_r9_rvalid_follows_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> reg_rvalid_o);

  a_r9_no_spurious_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> !reg_rvalid_o);

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind sc_cal_ctrl sc_cal_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_rd_i      (reg_rd_i),
  .reg_rvalid_o  (reg_rvalid_o),
  .force_frame_i (force_frame_i),
  .stat_o        (stat_o),
  .frame_start_o (frame_start_o),
  .err_o         (err_o),
  .act_i         (act_w),
  .hbwr_i        (hbwr_w),
  .rsfrm_i       (rsfrm_w)
);

// File: tb/sc_cal_ctrl_tb_top.sv
module sc_cal_ctrl_tb_top;
  localparam logic [15:0] ID_WORD = {3'd2, 13'h0A5C};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic        force_frame_i = 1'b0;
  logic [1:0]  stat_o;
  logic        frame_start_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_v[$];
  string       exp_t[$];
  logic [7:0]  bm0 [64];
  logic [7:0]  bm1 [64];
  logic [7:0]  len_m [2];
  logic [7:0]  rep_m [2];

  always #10 clk_i = ~clk_i;

  sc_cal_ctrl dut_i (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i,
    .reg_rdata_o, .reg_rvalid_o, .force_frame_i, .stat_o, .frame_start_o, .err_o
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for register reads
  always @(negedge clk_i) begin
    if (rst_ni && reg_rvalid_o) begin
      if (exp_v.size() == 0) chk(1'b0, "R9 unexpected rvalid", reg_rdata_o, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_t.pop_front();
        chk(reg_rdata_o === e, t, reg_rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    exp_v.push_back(e); exp_t.push_back(tag);
    reg_addr_i = a; reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic check_frame(input bit bank, input bit sel_on, input string tag);
    logic [1:0] w[$];
    logic [1:0] p;
    w.push_back(2'b11);
    if (sel_on) w.push_back(bank ? 2'b10 : 2'b01);
    for (int r = 0; r < rep_m[bank]; r++)
      for (int s = 0; s < len_m[bank]; s++)
        w.push_back(bank ? bm1[s][1:0] : bm0[s][1:0]);
    p = 2'b00;
    foreach (w[i]) p = p ^ w[i];
    w.push_back(p);
    while (!frame_start_o) @(negedge clk_i);
    foreach (w[i]) begin
      chk(stat_o === w[i], $sformatf("%s word %0d", tag, i), 16'(stat_o), 16'(w[i]));
      @(negedge clk_i);
    end
    chk(frame_start_o === 1'b1, {tag, " next boundary"}, 16'(frame_start_o), 16'h1);
  endtask

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    len_m[0] = 3; rep_m[0] = 2; len_m[1] = 2; rep_m[1] = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1, R2 reset state; R3 framing while disabled from reset
    chk(frame_start_o === 1'b1 && stat_o === 2'b11, "R3 reset framing", 16'(stat_o), 16'h3);
    chk(err_o === 1'b0, "R11 err reset", 16'(err_o), 16'h0);
    rd(4'd0, ID_WORD, "R1 identity word");
    rd(4'd1, 16'h0022, "R2 control reset value");

    // program bank 0 while disabled (R8, R11 open while disabled)
    wr(4'd2, 16'(rep_m[0]));
    wr(4'd4, 16'(len_m[0]));
    bm0[0] = 8'h11; bm0[1] = 8'h22; bm0[2] = 8'h33;
    for (int i = 0; i < 3; i++) begin
      wr(4'd6, 16'(i));
      wr(4'd7, 16'(bm0[i]));
    end
    wr(4'd6, 16'd1);
    rd(4'd7, 16'h0022, "R8 bank0 RAM read-back");
    rd(4'd4, 16'd3, "R7 bank0 length");

    // R10 bank 1 reserved while hbwr = 0
    wr(4'd5, 16'd9);
    wr(4'd3, 16'd4);
    rd(4'd5, 16'h0, "R10 len1 reads zero");
    rd(4'd3, 16'h0, "R10 rep1 reads zero");
    chk(err_o === 1'b0, "R10 no error on reserved write", 16'(err_o), 16'h0);

    // R3 leave disable; R7 frame without select word
    wr(4'd1, 16'h0000);
    check_frame(1'b0, 1'b0, "R7 bank0 frame");
    rd(4'd1, 16'h0000, "R2 enabled control word");

    // R11 blocked write to the active bank
    wr(4'd4, 16'd5);
    chk(err_o === 1'b1, "R11 err set", 16'(err_o), 16'h1);
    rd(4'd4, 16'd3, "R11 active length unchanged");

    // enable switching, program bank 1 (inactive, so writable)
    wr(4'd1, 16'h0001);
    wr(4'd3, 16'(rep_m[1]));
    wr(4'd5, 16'(len_m[1]));
    bm1[0] = 8'h40; bm1[1] = 8'h07;
    for (int i = 0; i < 2; i++) begin
      wr(4'd6, 16'(i));
      wr(4'd8, 16'(bm1[i]));
    end
    rd(4'd8, 16'h0007, "R8 bank1 RAM read-back");
    rd(4'd5, 16'd2, "R11 inactive bank write accepted");
    check_frame(1'b0, 1'b1, "R6 bank0 frame with select");

    // R5 request bank 1 just after a boundary
    while (!frame_start_o) @(negedge clk_i);
    wr(4'd1, 16'h0005);
    rd(4'd1, 16'h0005, "R5 active bank held until boundary");
    check_frame(1'b1, 1'b1, "R5 R6 bank1 frame");
    rd(4'd1, 16'h000D, "R5 bank1 active");

    // R11 protection follows the active bank
    wr(4'd4, 16'd1);
    len_m[0] = 1;
    rd(4'd4, 16'd1, "R11 bank0 writable while bank1 active");
    wr(4'd5, 16'd7);
    rd(4'd5, 16'd2, "R11 active bank1 length unchanged");
    chk(err_o === 1'b1, "R11 err sticky", 16'(err_o), 16'h1);

    // R4 external force
    force_frame_i = 1'b1;
    repeat (12) @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      chk(frame_start_o === 1'b1 && stat_o === 2'b11, "R4 forced framing", 16'(stat_o), 16'h3);
      @(negedge clk_i);
    end
    rd(4'd1, 16'h002D, "R4 disabled mirror under force");
    force_frame_i = 1'b0;
    @(negedge clk_i);
    check_frame(1'b1, 1'b1, "R4 resume after force");

    repeat (2) @(negedge clk_i);
    chk(exp_v.size() == 0, "R9 all reads answered", 16'(exp_v.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule